// File: doc/BRIEF.md
# Bit-Synchronous HDLC / PPP Frame Serialiser

This block turns a stream of payload bytes into a bit-serial HDLC frame stream, one line bit per cycle in which the clock enable is high. Bytes arrive on a valid/ready interface, and a marker on the final byte closes the frame. Each frame goes out as a flag, the payload, a 16-bit frame check sequence and a closing flag. A zero is inserted after every five consecutive ones in the payload and check sequence. When no frame is waiting, the line carries back-to-back flags.

A frame in progress can be cut short with an abort request. The block then sends a run of ones whose length depends on a mode input. That input selects plain HDLC or bit-synchronous PPP. After the abort, any bytes of that frame still waiting upstream are accepted and thrown away, up to and including the one marked last. Apart from the abort length, the two modes frame data in exactly the same way. No character mapping is done.

Top module: `hdlc_bitsync_tx`

## Requirements
- R1: While reset is held, and up to the first enabled bit after it, `tx_bit` is 1 and `in_ready` is 0. With no frame pending, the line carries continuous flags 0x7E, sent least significant bit first (0,1,1,1,1,1,1,0).
- R2: Every frame starts only after a complete flag and is followed by a closing flag. The closing flag of one frame may serve as the opening flag of the next.
- R3: Payload bytes go out in the order they were accepted, each least significant bit first. The received frame holds exactly the accepted bytes followed by two check bytes.
- R4: The check sequence is the ones complement of a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) computed over the payload bits in line order. It is sent low byte first, least significant bit first.
- R5: Inside a frame, a 0 is inserted after any five consecutive ones of payload or check sequence, including just before the closing flag. Flags and abort ones are never stuffed. The line never shows a run of ones longer than the PPP abort length plus five.
- R6: `tx_bit` changes only in the clock cycle after a cycle in which `bit_en` was high, and it holds its value otherwise.
- R7: `in_ready` is high only in a cycle with `bit_en` high in which the first bit of a new payload byte is being sent, or while leftover bytes of an aborted frame are being drained. It is low while flags or stuffed zeros are sent.
- R8: An `abort_req` seen in a cycle with `bit_en` high, during payload or check sequence, replaces the next line bit with the first of a run of ones. The run is 7 ones when `ppp_mode` is 0 and 15 when it is 1, with `ppp_mode` sampled when the abort starts. Flags follow the run.
- R9: After an abort, the remaining bytes of that frame up to and including the one with `in_last` are accepted without being sent, and the next frame goes out intact.
- R10: If no byte is valid when the next payload byte is needed, the frame is aborted exactly as in R8 and its remaining bytes are drained as in R9.
- R11: `abort_req` while only flags are being sent has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit enable; one line bit per high cycle |
| ppp_mode | input | 1 | 0 selects HDLC abort length, 1 selects PPP abort length |
| abort_req | input | 1 | Abort the frame in progress at the next enabled bit |
| in_valid | input | 1 | Payload byte on `in_data` is valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| tx_bit | output | 1 | Serial line bit |

## Verification
A wrong bit index or state in the serialiser shows up at the line as a malformed frame when the next flag is decoded. The symptom is a bit count that is not a whole number of bytes, a wrong payload byte, or a check sequence that does not match. This appears at most one frame length after the fault. A stale ones counter shows up as a missing or extra stuffed zero, and the bench receiver sees it within the same frame, as a false flag or a byte misaligned by one bit. A wrong abort counter or a missing drain shows up as a run of ones of the wrong length, or as leftover bytes that are sent as the start of the next frame. Both appear before the next good frame ends.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [1:0] {
        ST_FLAG  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FCS   = 2'd2,
        ST_ABORT = 2'd3
    } tx_state_e;

    localparam logic [7:0]  FLAG_PATTERN  = 8'h7E;
    localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
    localparam logic [15:0] FCS_PRESET    = 16'hFFFF;

    // One bit of the reflected CRC shift, bit taken in line order.
    function automatic logic [15:0] fcs_bit_step(input logic [15:0] cur,
                                                 input logic        din,
                                                 input logic [15:0] poly);
        logic fb;
        fb = cur[0] ^ din;
        fcs_bit_step = (cur >> 1) ^ (fb ? poly : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_tx_crc16.sv
module hdlc_tx_crc16
    import hdlc_tx_pkg::*;
#(
    parameter logic [15:0] POLY   = FCS_POLY_REFL,
    parameter logic [15:0] PRESET = FCS_PRESET
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        adv,
    input  logic        din,
    output logic [15:0] crc
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init) begin
            crc_d = PRESET;
        end else if (adv) begin
            crc_d = fcs_bit_step(crc_q, din, POLY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= PRESET;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/hdlc_tx_onesrun.sv
module hdlc_tx_onesrun #(
    parameter  int RUN_LIMIT = 5,
    localparam int RW        = $clog2(RUN_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic stuff_due
);

    localparam logic [RW-1:0] LIMIT = RW'(RUN_LIMIT);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d = din ? cnt_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign stuff_due = (cnt_q == LIMIT);

endmodule

// File: rtl/hdlc_bitsync_tx.sv
module hdlc_bitsync_tx
    import hdlc_tx_pkg::*;
#(
    parameter int ABORT_HDLC_LEN = 7,
    parameter int ABORT_PPP_LEN  = 15,
    parameter int STUFF_RUN      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       ppp_mode,
    input  logic       abort_req,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_bit
);

    localparam int BYTE_W   = 8;
    localparam int FCS_W    = 16;
    localparam int IW       = $clog2(FCS_W);
    localparam int ALEN_MAX = (ABORT_PPP_LEN > ABORT_HDLC_LEN) ? ABORT_PPP_LEN : ABORT_HDLC_LEN;
    localparam int AW       = $clog2(ALEN_MAX + 1);

    localparam logic [AW-1:0] LIM_HDLC  = AW'(ABORT_HDLC_LEN);
    localparam logic [AW-1:0] LIM_PPP   = AW'(ABORT_PPP_LEN);
    localparam logic [IW-1:0] IDX_BYTE  = IW'(BYTE_W - 1);
    localparam logic [IW-1:0] IDX_FCS   = IW'(FCS_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [IW-1:0]     idx;
        logic [BYTE_W-1:0] sh;
        logic              last;
        logic              drain;
        logic [AW-1:0]     acnt;
        logic [AW-1:0]     alim;
        logic              txb;
    } regs_t;

    regs_t q, d;

    logic        crc_init, crc_adv;
    logic        run_clr, run_adv;
    logic        stuff_due;
    logic [15:0] crc_val;
    logic        bitv;
    logic        last_now;
    logic        go_abort;
    logic        drain_on_abort;

    hdlc_tx_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .adv   (crc_adv),
        .din   (bitv),
        .crc   (crc_val)
    );

    hdlc_tx_onesrun #(.RUN_LIMIT(STUFF_RUN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (run_clr),
        .adv       (run_adv),
        .din       (bitv),
        .stuff_due (stuff_due)
    );

    always_comb begin
        d              = q;
        in_ready       = 1'b0;
        crc_init       = 1'b0;
        crc_adv        = 1'b0;
        run_clr        = 1'b0;
        run_adv        = 1'b0;
        bitv           = q.txb;
        last_now       = q.last;
        go_abort       = 1'b0;
        drain_on_abort = 1'b0;

        // Leftover bytes of an aborted frame are swallowed at full rate.
        if (q.drain) begin
            in_ready = 1'b1;
            if (in_valid && in_last) begin
                d.drain = 1'b0;
            end
        end

        if (bit_en) begin
            unique case (q.st)
                ST_FLAG: begin
                    if (q.idx == '0 && stuff_due) begin
                        // Trailing stuff bit owed by the check sequence.
                        bitv    = 1'b0;
                        run_clr = 1'b1;
                    end else begin
                        bitv    = FLAG_PATTERN[q.idx[2:0]];
                        run_clr = 1'b1;
                        if (q.idx == IDX_BYTE) begin
                            d.idx = '0;
                            if (in_valid && !q.drain) begin
                                d.st     = ST_DATA;
                                crc_init = 1'b1;
                            end
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_DATA, ST_FCS: begin
                    if (abort_req) begin
                        go_abort       = 1'b1;
                        drain_on_abort = (q.st == ST_DATA) && !((q.idx != '0) && q.last);
                    end else if (stuff_due) begin
                        bitv    = 1'b0;
                        run_clr = 1'b1;
                    end else if (q.st == ST_DATA) begin
                        if (q.idx == '0 && !in_valid) begin
                            go_abort       = 1'b1;
                            drain_on_abort = 1'b1;
                        end else begin
                            if (q.idx == '0) begin
                                in_ready = 1'b1;
                                d.sh     = in_data;
                                d.last   = in_last;
                                last_now = in_last;
                                bitv     = in_data[0];
                            end else begin
                                bitv = q.sh[q.idx[2:0]];
                            end
                            crc_adv = 1'b1;
                            run_adv = 1'b1;
                            if (q.idx == IDX_BYTE) begin
                                d.idx = '0;
                                if (last_now) begin
                                    d.st = ST_FCS;
                                end
                            end else begin
                                d.idx = q.idx + 1'b1;
                            end
                        end
                    end else begin
                        bitv    = ~crc_val[q.idx];
                        run_adv = 1'b1;
                        if (q.idx == IDX_FCS) begin
                            d.st  = ST_FLAG;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                default: begin
                    bitv    = 1'b1;
                    run_clr = 1'b1;
                    if (q.acnt + 1'b1 == q.alim) begin
                        d.st  = ST_FLAG;
                        d.idx = '0;
                    end else begin
                        d.acnt = q.acnt + 1'b1;
                    end
                end
            endcase

            if (go_abort) begin
                bitv    = 1'b1;
                run_clr = 1'b1;
                d.st    = ST_ABORT;
                d.idx   = '0;
                d.acnt  = AW'(1);
                d.alim  = ppp_mode ? LIM_PPP : LIM_HDLC;
                d.drain = drain_on_abort;
            end

            d.txb = bitv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_FLAG;
            q.idx   <= '0;
            q.sh    <= '0;
            q.last  <= 1'b0;
            q.drain <= 1'b0;
            q.acnt  <= '0;
            q.alim  <= LIM_HDLC;
            q.txb   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit = q.txb;

    // State views for the bound checker.
    logic chk_abort, chk_data, chk_drain;
    assign chk_abort = (q.st == ST_ABORT);
    assign chk_data  = (q.st == ST_DATA);
    assign chk_drain = q.drain;

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk #(
    parameter  int MAX_RUN = 20,
    localparam int RW      = $clog2(MAX_RUN + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_bit,
    input logic in_ready,
    input logic in_valid,
    input logic in_last,
    input logic st_abort,
    input logic st_data,
    input logic drain_busy
);

    logic          en_d;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
            run  <= '0;
        end else begin
            en_d <= bit_en;
            if (en_d) begin
                if (!tx_bit) begin
                    run <= '0;
                end else if (run != '1) begin
                    run <= run + 1'b1;
                end
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    assert_ready_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bit_en || drain_busy));

    assert_ready_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !drain_busy) |-> st_data);

    assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_abort && bit_en) |=> tx_bit);

    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(MAX_RUN));

    assert_drain_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_busy && in_valid && in_last) |=> !drain_busy);

endmodule

bind hdlc_bitsync_tx hdlc_tx_chk #(.MAX_RUN(ABORT_PPP_LEN + STUFF_RUN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_bit     (tx_bit),
    .in_ready   (in_ready),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .st_abort   (chk_abort),
    .st_data    (chk_data),
    .drain_busy (chk_drain)
);

// File: tb/hdlc_bitsync_tx_tb.sv
`timescale 1ns/1ps
module hdlc_bitsync_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       ppp_mode = 1'b0;
    logic       abort_req = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_bit;

    always #2 clk = ~clk;

    hdlc_bitsync_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .ppp_mode  (ppp_mode),
        .abort_req (abort_req),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .tx_bit    (tx_bit)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic en_seen = 1'b0;
    logic acc     = 1'b0;
    bit   drain_phase = 1'b0;
    bit   cur_ppp = 1'b0;
    int   en_pct  = 100;
    logic prev_tx = 1'b1;

    int   aborts_seen = 0;
    int   aborts_exp  = 0;
    int   frames_seen = 0;
    int   frames_exp  = 0;
    int   idle_flags  = 0;
    int   rx_ones     = 0;
    bit   synced      = 1'b0;
    logic rxq[$];
    int   exp_data[$];
    int   exp_len[$];
    int   fbuf[32];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fcs_of(input int b[$]);
        int c;
        c = 16'hFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                int fb;
                fb = (c ^ (b[i] >> k)) & 1;
                c = c >> 1;
                if (fb != 0) c = c ^ 16'h8408;
            end
        end
        return (~c) & 16'hFFFF;
    endfunction

    task automatic finish_frame();
        int n;
        int got[$];
        int want[$];
        int len;
        int mism;
        int f;
        n = rxq.size();
        if ((n % 8) != 0 || n < 24) begin
            check(1'b0, "R5", "frame bit count not whole bytes", n, 24);
            return;
        end
        for (int i = 0; i < n / 8; i++) begin
            int v;
            v = 0;
            for (int k = 0; k < 8; k++) if (rxq[i*8+k]) v = v | (1 << k);
            got.push_back(v);
        end
        frames_seen++;
        if (exp_len.size() == 0) begin
            check(1'b0, "R3", "unexpected frame", got.size(), 0);
            return;
        end
        len = exp_len.pop_front();
        for (int i = 0; i < len; i++) want.push_back(exp_data.pop_front());
        check(got.size() - 2 == len, "R3", "payload length", got.size() - 2, len);
        if (got.size() - 2 != len) return;
        mism = 0;
        for (int i = 0; i < len; i++) if (got[i] != want[i]) mism++;
        check(mism == 0, "R3", "payload bytes mismatched", mism, 0);
        f = fcs_of(want);
        check(got[len] == (f & 255), "R4", "FCS low byte", got[len], f & 255);
        check(got[len+1] == (f >> 8), "R4", "FCS high byte", got[len+1], f >> 8);
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            rx_ones++;
            if (synced) rxq.push_back(1'b1);
        end else begin
            if (rx_ones >= 7) begin
                int lim;
                lim = cur_ppp ? 15 : 7;
                aborts_seen++;
                check(rx_ones >= lim && rx_ones <= lim + 5, "R8", "abort run length", rx_ones, lim);
                rxq.delete();
                synced = 1'b1;
                rxq.push_back(1'b0);
            end else if (rx_ones == 6) begin
                if (synced) begin
                    repeat (7) if (rxq.size() > 0) void'(rxq.pop_back());
                    if (rxq.size() == 0) idle_flags++;
                    else finish_frame();
                end
                synced = 1'b1;
                rxq.delete();
            end else if (rx_ones == 5) begin
                // stuffed zero, dropped
            end else if (synced) begin
                rxq.push_back(1'b0);
            end
            rx_ones = 0;
        end
    endtask

    always @(negedge clk) begin
        bit_en = (en_pct >= 100) ? 1'b1 : ($urandom_range(99) < en_pct);
    end

    always @(posedge clk) begin
        en_seen <= bit_en && rst_n;
        acc     <= in_valid && in_ready;
        if (rst_n && in_ready && !drain_phase)
            check(bit_en, "R7", "ready high without bit enable", 0, 1);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (en_seen) rx_bit(tx_bit);
            else check(tx_bit == prev_tx, "R6", "line changed without bit enable", tx_bit, prev_tx);
            prev_tx = tx_bit;
        end
    end

    // Sends fbuf[0..len-1]; abort_at / gap_at (1-based byte count) cut the frame.
    task automatic send(input int len, input bit ppp, input int abort_at, input int gap_at);
        int prev;
        int accepted;
        cur_ppp  = ppp;
        ppp_mode = ppp;
        prev     = aborts_seen;
        accepted = 0;
        if (abort_at == 0 && gap_at == 0) begin
            exp_len.push_back(len);
            for (int i = 0; i < len; i++) exp_data.push_back(fbuf[i]);
            frames_exp++;
        end else begin
            aborts_exp++;
        end
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = fbuf[i][7:0];
            in_last  = (i == len - 1);
            @(negedge clk);
            while (!acc) @(negedge clk);
            accepted++;
            if (i + 1 == abort_at) begin
                in_valid    = 1'b0;
                drain_phase = 1'b1;
                abort_req   = 1'b1;
                @(negedge clk);
                while (!en_seen) @(negedge clk);
                abort_req = 1'b0;
            end
            if (i + 1 == gap_at) begin
                in_valid    = 1'b0;
                drain_phase = 1'b1;
                repeat (60) @(negedge clk);
            end
        end
        in_valid    = 1'b0;
        in_last     = 1'b0;
        drain_phase = 1'b0;
        if (abort_at != 0 || gap_at != 0) begin
            check(accepted == len, "R9", "leftover bytes drained", accepted, len);
            while (aborts_seen <= prev) @(negedge clk);
            check(aborts_seen == prev + 1, gap_at != 0 ? "R10" : "R8",
                  "abort seen on line", aborts_seen - prev, 1);
        end
    endtask

    task automatic wait_quiet();
        while (exp_len.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    initial begin
        int fl;
        int ab;
        void'($urandom(32'd1215));
        repeat (5) @(negedge clk);
        check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
        check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;

        repeat (120) @(negedge clk);
        check(idle_flags >= 8, "R1", "idle flags seen", idle_flags, 8);

        fbuf[0] = 8'h7E;
        send(1, 1'b0, 0, 0);
        fbuf[0] = 8'hFF; fbuf[1] = 8'hFF; fbuf[2] = 8'hFF;
        send(3, 1'b0, 0, 0);
        fbuf[0] = 8'h00;
        send(1, 1'b1, 0, 0);
        fbuf[0] = 8'h7D; fbuf[1] = 8'h7E; fbuf[2] = 8'hFF; fbuf[3] = 8'h55;
        send(4, 1'b0, 0, 0);
        wait_quiet();
        check(frames_seen == 4, "R2", "directed frames delimited by flags", frames_seen, 4);

        en_pct = 60;
        for (int i = 0; i < 6; i++) fbuf[i] = 8'hF0 + i;
        send(6, 1'b0, 2, 0);
        for (int i = 0; i < 5; i++) fbuf[i] = 8'hFF;
        send(5, 1'b1, 1, 0);
        fbuf[0] = 8'h12; fbuf[1] = 8'h34;
        send(2, 1'b0, 0, 0);
        for (int i = 0; i < 4; i++) fbuf[i] = 8'hA5;
        send(4, 1'b1, 0, 2);
        fbuf[0] = 8'h99;
        send(1, 1'b1, 0, 0);
        wait_quiet();

        fl = idle_flags;
        ab = aborts_seen;
        abort_req = 1'b1;
        repeat (40) @(negedge clk);
        abort_req = 1'b0;
        repeat (60) @(negedge clk);
        check(aborts_seen == ab, "R11", "abort while idle", aborts_seen - ab, 0);
        check(idle_flags > fl, "R11", "flags continue while idle abort held", idle_flags - fl, 1);

        for (int f = 0; f < 24; f++) begin
            int len;
            int abt;
            len = 1 + $urandom_range(11);
            for (int i = 0; i < len; i++)
                fbuf[i] = ($urandom_range(3) == 0) ? 8'hFF : $urandom_range(255);
            case ($urandom_range(2))
                0: en_pct = 100;
                1: en_pct = 60;
                default: en_pct = 35;
            endcase
            abt = (len >= 2 && $urandom_range(4) == 0) ? 1 + $urandom_range(len - 2) : 0;
            send(len, $urandom_range(1) == 1, abt, 0);
        end
        wait_quiet();
        repeat (200) @(negedge clk);

        check(frames_seen == frames_exp, "R3", "total frames received", frames_seen, frames_exp);
        check(aborts_seen == aborts_exp, "R9", "total aborts on line", aborts_seen, aborts_exp);
        check(exp_len.size() == 0, "R2", "frames still outstanding", exp_len.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule